// File: doc/BRIEF.md
# Programmable Clock Divider with Deferred Reload

This block turns a stream of input clock-enable pulses into a slower square wave. The division ratio comes from a programmable time constant. A down counter steps once for each input pulse. When it reaches zero it reloads from the time-constant register and raises a one-cycle terminal-count strobe.

The output is set high at every reload and is cleared when the count steps down to half of the active time constant. The division ratio is therefore the time constant plus one, from 1 down to 1/65536 with the default 16-bit width.

Software may write the time constant at any moment, and the period in progress is not disturbed. The counter takes up the new value only at its next reload. An enable input starts the generator and loads the counter from the register at once.

Top module: `baud_divider`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first enable, `div_out` and `tc_strobe` are 0 and the time-constant register holds 0.
- R2: At a clock edge where `gen_en` is 1 and the generator is idle, the counter loads the register value and `div_out` becomes 1. A `tick` in that same cycle is not counted, and no strobe is raised.
- R3: While the generator runs, the count changes only at edges where `tick` is 1. With `tick` at 0, `div_out` and `tc_strobe` stay unchanged and low respectively.
- R4: At a ticked edge with the count at 0, the counter reloads from the register and `div_out` is set to 1. `tc_strobe` is 1 for exactly the cycle after that edge.
- R5: With a constant time constant T, consecutive strobes are T+1 ticks apart.
- R6: `div_out` falls at the ticked edge where the count steps down to (A>>1), A being the time constant taken at the last load. The high phase therefore lasts A-(A>>1) ticks and the low phase (A>>1)+1 ticks.
- R7: A write on `tc_wr` changes neither the count in progress nor the halfway point. The new value is used first at the next reload.
- R8: With a time constant of 0, every ticked edge produces a strobe and `div_out` stays 1.
- R9: At an edge where `gen_en` is 0, `div_out` and `tc_strobe` become 0 and the generator goes idle. The next enable reloads the counter as described in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously outside the block |
| gen_en | input | 1 | Runs the generator while 1 |
| tick | input | 1 | One-cycle input clock-enable pulse that steps the counter |
| tc_wr | input | 1 | Write strobe for the time-constant register |
| tc_wdata | input | TC_W | New time-constant value |
| div_out | output | 1 | Divided square-wave output |
| tc_strobe | output | 1 | One-cycle pulse after each reload |

## Verification
Fixed time constants with `tick` held high each cycle measure the strobe spacing and the split between the high and low phases. These runs separate an off-by-one in the reload from an off-by-one in the halfway compare, and an even constant from an odd one.

A write in the middle of a period, followed by two measured periods, tells deferred loading apart from immediate loading. A zero constant and long stretches without `tick` expose wrong handling of the degenerate ratio and of gating.

A long random phase follows, with sparse ticks, random writes and enable drops. It is compared cycle by cycle against a bench model and catches ordering faults between enable, reload and write.

// File: rtl/bdg_pkg.sv
package bdg_pkg;
  typedef enum logic [0:0] {
    BDG_IDLE = 1'b0,
    BDG_RUN  = 1'b1
  } bdg_state_e;
endpackage

// File: rtl/bdg_tc_reg.sv
module bdg_tc_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] tc_q
);
  logic [W-1:0] tc_d;

  always_comb begin
    tc_d = tc_q;
    if (wr) tc_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tc_q <= '0;
    else        tc_q <= tc_d;
  end
endmodule

// File: rtl/bdg_counter.sv
module bdg_counter
  import bdg_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         tick,
  input  logic [W-1:0] tc_in,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] act_q,
  output logic         run_q,
  output logic         start_o,
  output logic         reload_o,
  output logic         half_o,
  output logic         strobe_q
);
  bdg_state_e   st_q, st_d;
  logic [W-1:0] cnt_d, act_d, half_val, cnt_dec;
  logic         strobe_d, at_zero;

  assign half_val = act_q >> 1;
  assign cnt_dec  = cnt_q - 1'b1;
  assign at_zero  = (cnt_q == '0);
  assign run_q    = (st_q == BDG_RUN);

  assign start_o  = en && (st_q == BDG_IDLE);
  assign reload_o = en && run_q && tick && at_zero;
  assign half_o   = en && run_q && tick && !at_zero && (cnt_dec == half_val);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    act_d    = act_q;
    strobe_d = 1'b0;
    if (!en) begin
      st_d = BDG_IDLE;
    end else if (st_q == BDG_IDLE) begin
      st_d  = BDG_RUN;
      cnt_d = tc_in;
      act_d = tc_in;
    end else if (tick) begin
      if (at_zero) begin
        cnt_d    = tc_in;
        act_d    = tc_in;
        strobe_d = 1'b1;
      end else begin
        cnt_d = cnt_dec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= BDG_IDLE;
      cnt_q    <= '0;
      act_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      cnt_q    <= cnt_d;
      act_q    <= act_d;
      strobe_q <= strobe_d;
    end
  end
endmodule

// File: rtl/bdg_wave.sv
module bdg_wave (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start,
  input  logic reload,
  input  logic half,
  output logic out_q
);
  logic out_d;

  always_comb begin
    out_d = out_q;
    if (!en)                  out_d = 1'b0;
    else if (start || reload) out_d = 1'b1;
    else if (half)            out_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int unsigned TC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gen_en,
  input  logic            tick,
  input  logic            tc_wr,
  input  logic [TC_W-1:0] tc_wdata,
  output logic            div_out,
  output logic            tc_strobe
);
  logic [TC_W-1:0] tc_q, cnt_q, act_q;
  logic            run_q, start_w, reload_w, half_w;

  bdg_tc_reg #(.W(TC_W)) u_tc (
    .clk(clk), .rst_n(rst_n), .wr(tc_wr), .wdata(tc_wdata), .tc_q(tc_q)
  );

  bdg_counter #(.W(TC_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(gen_en), .tick(tick), .tc_in(tc_q),
    .cnt_q(cnt_q), .act_q(act_q), .run_q(run_q), .start_o(start_w),
    .reload_o(reload_w), .half_o(half_w), .strobe_q(tc_strobe)
  );

  bdg_wave u_wave (
    .clk(clk), .rst_n(rst_n), .en(gen_en), .start(start_w),
    .reload(reload_w), .half(half_w), .out_q(div_out)
  );
endmodule

// File: rtl/baud_divider_chk.sv
module baud_divider_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         gen_en,
  input logic         tick,
  input logic         div_out,
  input logic         tc_strobe,
  input logic         run_q,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] act_q,
  input logic [W-1:0] tc_q
);
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (!div_out && !tc_strobe)); // R9

  AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && !run_q) |=> (div_out && !tc_strobe && cnt_q == $past(tc_q))); // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && run_q && !tick) |=> ($stable(cnt_q) && $stable(div_out) && !tc_strobe)); // R3

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && run_q && tick && cnt_q == '0) |=> (tc_strobe && div_out && cnt_q == $past(tc_q))); // R4

  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_en && run_q && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1 && $stable(act_q))); // R7

  AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(div_out) && run_q) |-> (cnt_q == (act_q >> 1))); // R6

  AST_STROBE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tc_strobe |-> $past(tick)); // R4
endmodule

bind baud_divider baud_divider_chk #(.W(TC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .tick(tick),
  .div_out(div_out), .tc_strobe(tc_strobe), .run_q(run_q),
  .cnt_q(cnt_q), .act_q(act_q), .tc_q(tc_q)
);

// File: tb/baud_divider_bench.sv
`timescale 1ns/1ps
module baud_divider_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         gen_en = 1'b0;
  logic         tick = 1'b0;
  logic         tc_wr = 1'b0;
  logic [W-1:0] tc_wdata = '0;
  logic         div_out, tc_strobe;

  int n_chk = 0;
  int n_err = 0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  baud_divider #(.TC_W(W)) u_baud_divider (
    .clk(clk), .rst_n(rst_n), .gen_en(gen_en), .tick(tick),
    .tc_wr(tc_wr), .tc_wdata(tc_wdata), .div_out(div_out), .tc_strobe(tc_strobe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // Reference behaviour written from the requirements (R2, R4, R6, R7, R9)
  logic         m_run, m_out, m_stb;
  logic [W-1:0] m_cnt, m_act, m_tc;

  function automatic logic [W-1:0] half_of(input logic [W-1:0] a);
    return a >> 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run <= 1'b0; m_out <= 1'b0; m_stb <= 1'b0;
      m_cnt <= '0; m_act <= '0; m_tc <= '0;
    end else begin
      m_stb <= 1'b0;
      if (!gen_en) begin
        m_run <= 1'b0; m_out <= 1'b0;
      end else if (!m_run) begin
        m_run <= 1'b1; m_cnt <= m_tc; m_act <= m_tc; m_out <= 1'b1;
      end else if (tick) begin
        if (m_cnt == '0) begin
          m_cnt <= m_tc; m_act <= m_tc; m_out <= 1'b1; m_stb <= 1'b1;
        end else begin
          m_cnt <= m_cnt - 1'b1;
          if (m_cnt - 1'b1 == half_of(m_act)) m_out <= 1'b0;
        end
      end
      if (tc_wr) m_tc <= tc_wdata;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(div_out == m_out, "R6 div_out vs model", int'(div_out), int'(m_out));
      chk(tc_strobe == m_stb, "R4 tc_strobe vs model", int'(tc_strobe), int'(m_stb));
    end
  end

  task automatic write_tc(input int v);
    @(negedge clk); tc_wr = 1'b1; tc_wdata = W'(v);
    @(negedge clk); tc_wr = 1'b0;
  endtask

  // Returns at a negedge where tc_strobe is 1
  task automatic wait_strobe(output bit got);
    got = 1'b0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (tc_strobe) begin got = 1'b1; break; end
    end
  endtask

  task automatic measure_gap(output int gap);
    gap = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk); gap++;
      if (tc_strobe) break;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    bit got;
    int gap, hi, lo;
    void'($urandom(32'd2024));

    repeat (3) @(negedge clk);
    chk(div_out == 1'b0, "R1 div_out in reset", int'(div_out), 0);
    chk(tc_strobe == 1'b0, "R1 tc_strobe in reset", int'(tc_strobe), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(div_out == 1'b0 && tc_strobe == 1'b0, "R1 idle after reset", int'(div_out), 0);
    cmp_on = 1'b1;

    // R1: register resets to 0, so an immediate enable runs at ratio 1
    gen_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    chk(div_out == 1'b1 && tc_strobe == 1'b0, "R2 start edge", int'(tc_strobe), 0);
    repeat (3) begin
      @(negedge clk);
      chk(tc_strobe == 1'b1 && div_out == 1'b1, "R8 zero constant strobe each tick", int'(tc_strobe), 1);
    end

    // R5: period for T = 5 and T = 12
    write_tc(5);
    wait_strobe(got);
    measure_gap(gap); chk(gap == 6, "R5 period T=5", gap, 6);
    measure_gap(gap); chk(gap == 6, "R5 period T=5 repeat", gap, 6);
    write_tc(12);
    wait_strobe(got);
    measure_gap(gap); chk(gap == 13, "R5 period T=12", gap, 13);

    // R6: phase split for even T=4 (high 2, low 3) and odd T=7 (high 4, low 4)
    write_tc(4);
    wait_strobe(got); wait_strobe(got);
    hi = 0; lo = 0;
    while (div_out) begin hi++; @(negedge clk); end
    while (!div_out) begin lo++; @(negedge clk); end
    chk(hi == 2, "R6 high phase T=4", hi, 2);
    chk(lo == 3, "R6 low phase T=4", lo, 3);
    write_tc(7);
    wait_strobe(got); wait_strobe(got);
    hi = 0; lo = 0;
    while (div_out) begin hi++; @(negedge clk); end
    while (!div_out) begin lo++; @(negedge clk); end
    chk(hi == 4, "R6 high phase T=7", hi, 4);
    chk(lo == 4, "R6 low phase T=7", lo, 4);

    // R7: mid-period write is deferred to the next reload
    write_tc(9);
    wait_strobe(got); wait_strobe(got);
    repeat (2) @(negedge clk);
    tc_wr = 1'b1; tc_wdata = W'(3);
    @(negedge clk); tc_wr = 1'b0;
    measure_gap(gap); chk(gap == 7, "R7 current period kept (10 total)", gap, 7);
    measure_gap(gap); chk(gap == 4, "R7 new constant after reload", gap, 4);

    // R3: no ticks, nothing moves
    tick = 1'b0;
    hi = int'(div_out);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(tc_strobe == 1'b0 && int'(div_out) == hi, "R3 hold without tick", int'(div_out), hi);
    end
    tick = 1'b1;

    // R9 then R2: disable and restart
    gen_en = 1'b0;
    @(negedge clk);
    chk(div_out == 1'b0 && tc_strobe == 1'b0, "R9 disabled outputs", int'(div_out), 0);
    write_tc(2);
    gen_en = 1'b1;
    @(negedge clk);
    chk(div_out == 1'b1 && tc_strobe == 1'b0, "R2 restart loads", int'(div_out), 1);
    measure_gap(gap); chk(gap == 3, "R2 first period after enable", gap, 3);

    // Random phase, compared against the model every cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      tick   = ($urandom % 3) != 0;
      tc_wr  = ($urandom % 25) == 0;
      tc_wdata = (($urandom % 10) == 0) ? W'($urandom) : W'($urandom % 20);
      if (($urandom % 300) == 0) gen_en = ~gen_en;
      else if (!gen_en && ($urandom % 8) == 0) gen_en = 1'b1;
    end
    tc_wr = 1'b0;
    @(negedge clk);
    cmp_on = 1'b0;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule